// File: doc/BRIEF.md
# Duplex Word Mailbox

This block passes 32-bit words between two processors. Each processor sees a small register window. A write to its send port places a word in a FIFO. The other processor takes that word, in order, from its own receive port. There is one FIFO for each direction, so the two sides can talk at the same time without waiting on each other.

Each side also has a control word. It reports the empty and full state of both FIFOs that the side can reach, and it holds two interrupt enables. It carries a flush command for the side's outgoing FIFO and a sticky error flag for bad accesses. A master enable gates all data movement for that side.

Each side has two interrupt outputs. The first is a one-cycle pulse when its outgoing FIFO drains to empty. The second is a level that stays high while incoming words are waiting. How these interrupts are routed and how the bus reaches the window are left to the surrounding chip.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset, both FIFOs are empty. Every control word reads 0x00000101, every receive port reads 0, and all interrupt outputs are low.
- R2: A word written at offset 0x8 by side s while side s is enabled and its send FIFO is not full is returned, in write order, by reads at offset 0xC on the other side. Each such read removes one word.
- R3: In the control word (offset 0x4), bit 0 is set when the side's own send FIFO is empty and bit 1 when it holds 16 words. Bit 8 is set when the incoming FIFO is empty and bit 9 when it holds 16 words.
- R4: A write to a full send FIFO is discarded, and a read of an empty receive FIFO returns the last word read without removing anything. Either access, made while enabled, sets control bit 14.
- R5: Control bit 14 stays set until the same side writes its control word with bit 14 equal to 1. A control write with bit 14 equal to 0 leaves it unchanged.
- R6: A control write with bit 3 equal to 1 empties the side's own send FIFO, which is the other side's receive FIFO. It leaves bit 14 unchanged, and bit 3 always reads 0.
- R7: While control bit 15 of a side is 0, that side's send writes and receive reads move no data and set no error. A receive read then returns the last word read.
- R8: The receive interrupt of a side is high exactly when its control bit 10 is 1 and its incoming FIFO is not empty.
- R9: The send interrupt of a side is high for exactly one cycle when its send FIFO goes from non-empty to empty while control bit 2 is 1.
- R10: Control bits 2, 10 and 15 read back as last written. Bits 4 to 7, 11 to 13 and 16 to 31 read 0, and offsets 0x0 and 0x8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Access strobe, one bit per side |
| bus_wr | input | 2 | 1 = write, 0 = read, one bit per side |
| bus_addr | input | 2x4 | Byte offset into the register window, per side |
| bus_wdata | input | 2x32 | Write data, per side |
| bus_rdata | output | 2x32 | Read data for the addressed register, combinational, per side |
| irq_send_empty | output | 2 | One-cycle pulse when a side's send FIFO drains to empty |
| irq_recv_ready | output | 2 | High while a side has incoming words and bit 10 is set |

## Verification
The bench fills a FIFO to its last slot and then pushes once more. A design with an off-by-one in its full logic would lose or overwrite a word, or would fail to raise the error bit. It reads an empty receive port, expecting the previous word back with no pop; a design that pops anyway would return stale storage and wrap its pointers. It flushes while the error flag is set, which catches flush logic that also clears the error. It makes accesses while the side is disabled, which exposes an enable that gates only one direction. It also times the drain pulse to a single cycle after the emptying read, which catches an interrupt that is held as a level or delayed by a register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NSIDE  = 2;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_SEND = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_RECV = 4'hC;

    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_FULL  = 1;
    localparam int B_TX_IE    = 2;
    localparam int B_FLUSH    = 3;
    localparam int B_RX_EMPTY = 8;
    localparam int B_RX_FULL  = 9;
    localparam int B_RX_IE    = 10;
    localparam int B_ERR      = 14;
    localparam int B_ENABLE   = 15;

    typedef struct packed {
        logic enable;
        logic err;
        logic rx_ie;
        logic tx_ie;
    } ctrl_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTRL_WR,
        ACC_SEND_WR,
        ACC_RECV_RD
    } acc_t;

    typedef struct packed {
        logic empty;
        logic full;
    } fstat_t;

    function automatic acc_t decode_acc(input logic sel, input logic wr,
                                        input logic [ADDR_W-1:0] addr);
        acc_t k;
        k = ACC_NONE;
        if (sel) begin
            if (wr && addr == OFS_CTRL)       k = ACC_CTRL_WR;
            else if (wr && addr == OFS_SEND)  k = ACC_SEND_WR;
            else if (!wr && addr == OFS_RECV) k = ACC_RECV_RD;
        end
        return k;
    endfunction

    function automatic logic [15:0] pack_ctrl(input ctrl_t c, input fstat_t tx,
                                              input fstat_t rx);
        logic [15:0] v;
        v             = '0;
        v[B_TX_EMPTY] = tx.empty;
        v[B_TX_FULL]  = tx.full;
        v[B_TX_IE]    = c.tx_ie;
        v[B_RX_EMPTY] = rx.empty;
        v[B_RX_FULL]  = rx.full;
        v[B_RX_IE]    = c.rx_ie;
        v[B_ERR]      = c.err;
        v[B_ENABLE]   = c.enable;
        return v;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !rst && !clr) store[wptr] <= din;
    end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  fstat_t            tx_st,
    input  fstat_t            rx_st,
    input  logic [W-1:0]      rx_head,
    output logic [W-1:0]      rdata,
    output logic              push,
    output logic              pop,
    output logic              flush,
    output logic              enabled,
    output logic              irq_tx,
    output logic              irq_rx
);
    ctrl_t       ctrl;
    acc_t        kind;
    logic [W-1:0] last_rd;
    logic        tx_empty_q;
    logic        bad_acc;

    assign kind    = decode_acc(sel, wr, addr);
    assign enabled = ctrl.enable;
    assign push    = (kind == ACC_SEND_WR) && ctrl.enable && !tx_st.full;
    assign pop     = (kind == ACC_RECV_RD) && ctrl.enable && !rx_st.empty;
    assign flush   = (kind == ACC_CTRL_WR) && wdata[B_FLUSH];
    assign bad_acc = ctrl.enable &&
                     (((kind == ACC_SEND_WR) && tx_st.full) ||
                      ((kind == ACC_RECV_RD) && rx_st.empty));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            last_rd    <= '0;
            tx_empty_q <= 1'b1;
        end else begin
            tx_empty_q <= tx_st.empty;
            if (kind == ACC_CTRL_WR) begin
                ctrl.enable <= wdata[B_ENABLE];
                ctrl.rx_ie  <= wdata[B_RX_IE];
                ctrl.tx_ie  <= wdata[B_TX_IE];
                if (wdata[B_ERR]) ctrl.err <= 1'b0;
            end else if (bad_acc) begin
                ctrl.err <= 1'b1;
            end
            if (pop) last_rd <= rx_head;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            unique case (addr)
                OFS_CTRL: rdata = W'(pack_ctrl(ctrl, tx_st, rx_st));
                OFS_RECV: rdata = (ctrl.enable && !rx_st.empty) ? rx_head : last_rd;
                default:  rdata = '0;
            endcase
        end
    end

    assign irq_tx = ctrl.tx_ie && tx_st.empty && !tx_empty_q;
    assign irq_rx = ctrl.rx_ie && !rx_st.empty;
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NSIDE-1:0]              bus_sel,
    input  logic [NSIDE-1:0]              bus_wr,
    input  logic [NSIDE-1:0][ADDR_W-1:0]  bus_addr,
    input  logic [NSIDE-1:0][W-1:0]       bus_wdata,
    output logic [NSIDE-1:0][W-1:0]       bus_rdata,
    output logic [NSIDE-1:0]              irq_send_empty,
    output logic [NSIDE-1:0]              irq_recv_ready
);
    logic [NSIDE-1:0]         fifo_empty, fifo_full, push, pop, flush, side_en;
    logic [NSIDE-1:0][CW-1:0] fifo_count;
    logic [NSIDE-1:0][W-1:0]  fifo_head;

    // FIFO s carries words sent by side s; the other side pops it.
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int PEER = NSIDE - 1 - s;
        fstat_t tx_st, rx_st;

        assign tx_st = '{empty: fifo_empty[s],    full: fifo_full[s]};
        assign rx_st = '{empty: fifo_empty[PEER], full: fifo_full[PEER]};

        mbx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .clr   (flush[s]),
            .push  (push[s]),
            .din   (bus_wdata[s]),
            .pop   (pop[PEER]),
            .dout  (fifo_head[s]),
            .empty (fifo_empty[s]),
            .full  (fifo_full[s]),
            .count (fifo_count[s])
        );

        mbx_port #(.W(W)) u_port (
            .clk     (clk),
            .rst     (rst),
            .sel     (bus_sel[s]),
            .wr      (bus_wr[s]),
            .addr    (bus_addr[s]),
            .wdata   (bus_wdata[s]),
            .tx_st   (tx_st),
            .rx_st   (rx_st),
            .rx_head (fifo_head[PEER]),
            .rdata   (bus_rdata[s]),
            .push    (push[s]),
            .pop     (pop[s]),
            .flush   (flush[s]),
            .enabled (side_en[s]),
            .irq_tx  (irq_send_empty[s]),
            .irq_rx  (irq_recv_ready[s])
        );
    end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NSIDE-1:0]             bus_sel,
    input logic [NSIDE-1:0]             bus_wr,
    input logic [NSIDE-1:0][ADDR_W-1:0] bus_addr,
    input logic [NSIDE-1:0]             fifo_empty,
    input logic [NSIDE-1:0]             fifo_full,
    input logic [NSIDE-1:0][CW-1:0]     fifo_count,
    input logic [NSIDE-1:0]             flush,
    input logic [NSIDE-1:0]             side_en,
    input logic [NSIDE-1:0]             irq_send_empty,
    input logic [NSIDE-1:0]             irq_recv_ready
);
    for (genvar s = 0; s < NSIDE; s++) begin : g_chk
        localparam int PEER = NSIDE - 1 - s;
        logic send_try;
        assign send_try = bus_sel[s] && bus_wr[s] && bus_addr[s] == OFS_SEND;

        assert_flags_sane_R3: assert property (@(posedge clk) disable iff (rst)
            !(fifo_empty[s] && fifo_full[s]));

        assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
            fifo_count[s] <= CW'(DEPTH));

        assert_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
            (send_try && fifo_full[s]) |=> fifo_count[s] <= $past(fifo_count[s]));

        assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
            flush[s] |=> fifo_empty[s]);

        assert_disabled_no_push_R7: assert property (@(posedge clk) disable iff (rst)
            (send_try && !side_en[s]) |=> fifo_count[s] <= $past(fifo_count[s]));

        assert_rx_level_R8: assert property (@(posedge clk) disable iff (rst)
            irq_recv_ready[s] |-> !fifo_empty[PEER]);

        assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
            irq_send_empty[s] |=> !irq_send_empty[s]);

        assert_tx_pulse_empty_R9: assert property (@(posedge clk) disable iff (rst)
            irq_send_empty[s] |-> fifo_empty[s]);
    end
endmodule

bind duplex_mailbox mbx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .fifo_empty     (fifo_empty),
    .fifo_full      (fifo_full),
    .fifo_count     (fifo_count),
    .flush          (flush),
    .side_en        (side_en),
    .irq_send_empty (irq_send_empty),
    .irq_recv_ready (irq_recv_ready)
);

// File: tb/sim_duplex_mailbox.sv
module sim_duplex_mailbox;
    localparam int DEPTH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       sel = '0, wr = '0;
    logic [1:0][3:0]  addr = '0;
    logic [1:0][31:0] wdata = '0;
    logic [1:0][31:0] rdata;
    logic [1:0]       irq_tx, irq_rx;

    int checks = 0, fails = 0;
    bit done = 0;

    // Model state
    logic [31:0] q0[$], q1[$];
    logic [31:0] last_rd [2];
    bit en [2], err [2], txie [2], rxie [2];

    always #5 clk = ~clk;

    duplex_mailbox u0 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_send_empty(irq_tx), .irq_recv_ready(irq_rx)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int qsize(input int s);
        return (s == 0) ? q0.size() : q1.size();
    endfunction

    function automatic logic [31:0] exp_ctrl(input int s);
        logic [31:0] v = '0;
        v[0]  = qsize(s) == 0;
        v[1]  = qsize(s) == DEPTH;
        v[2]  = txie[s];
        v[8]  = qsize(1 - s) == 0;
        v[9]  = qsize(1 - s) == DEPTH;
        v[10] = rxie[s];
        v[14] = err[s];
        v[15] = en[s];
        return v;
    endfunction

    task automatic acc(input int s, input bit w, input logic [3:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        sel[s] = 1'b1; wr[s] = w; addr[s] = a; wdata[s] = d;
        #1 rd = rdata[s];
        @(posedge clk);
        #1 sel[s] = 1'b0; wr[s] = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input int s, input logic [31:0] d);
        logic [31:0] rd;
        acc(s, 1'b1, 4'h8, d, rd);
        if (en[s]) begin
            if (qsize(s) < DEPTH) begin
                if (s == 0) q0.push_back(d); else q1.push_back(d);
            end else err[s] = 1;
        end
    endtask

    task automatic recv(input int s, input string tag);
        logic [31:0] rd, exp;
        exp = last_rd[s];
        if (en[s]) begin
            if (qsize(1 - s) == 0) err[s] = 1;
            else begin
                exp = (s == 0) ? q1.pop_front() : q0.pop_front();
                last_rd[s] = exp;
            end
        end
        acc(s, 1'b0, 4'hC, '0, rd);
        chk(rd === exp, tag, rd, exp);
    endtask

    task automatic wctrl(input int s, input logic [31:0] v);
        logic [31:0] rd;
        acc(s, 1'b1, 4'h4, v, rd);
        txie[s] = v[2]; rxie[s] = v[10]; en[s] = v[15];
        if (v[14]) err[s] = 0;
        if (v[3]) begin
            if (s == 0) q0.delete(); else q1.delete();
        end
    endtask

    task automatic rctrl(input int s, input string tag);
        logic [31:0] rd, exp;
        exp = exp_ctrl(s);
        acc(s, 1'b0, 4'h4, '0, rd);
        chk(rd === exp, tag, rd, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 2; i++) begin
            last_rd[i] = '0; en[i] = 0; err[i] = 0; txie[i] = 0; rxie[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < 2; s++) begin
            rctrl(s, "R1 ctrl after reset");
            recv(s, "R1 recv after reset");
        end
        chk(irq_tx === 2'b00 && irq_rx === 2'b00, "R1 irqs low",
            {28'b0, irq_tx, irq_rx}, 32'h0);

        // R7: disabled side moves nothing, no error
        send(0, 32'hDEAD0001);
        rctrl(1, "R7 disabled send not delivered");
        rctrl(0, "R7 disabled no error");

        // R10: readback of enable bits, unused bits zero
        wctrl(0, 32'hFFFF_FFFF);
        rctrl(0, "R10 all-ones write readback");
        acc(0, 1'b0, 4'h0, '0, rd);
        chk(rd === 32'h0, "R10 offset 0 reads 0", rd, 32'h0);
        acc(0, 1'b0, 4'h8, '0, rd);
        chk(rd === 32'h0, "R10 send port reads 0", rd, 32'h0);
        wctrl(0, 32'h0000_8000);
        wctrl(1, 32'h0000_8000);
        rctrl(1, "R10 enable readback");

        // R2/R3/R4: fill to full, overflow, drain, underflow
        for (int i = 0; i < DEPTH; i++) send(0, 32'hA000_0000 + i);
        rctrl(0, "R3 send full status");
        rctrl(1, "R3 recv full status");
        send(0, 32'hBAD0_BAD0);
        rctrl(0, "R4 overflow sets error");
        for (int i = 0; i < DEPTH; i++) recv(1, "R2 order after fill");
        rctrl(1, "R3 recv empty status");
        recv(1, "R4 empty read returns last word");
        rctrl(1, "R4 underflow sets error");

        // R5: acknowledge
        wctrl(1, 32'h0000_8000);
        rctrl(1, "R5 write 0 keeps error");
        wctrl(1, 32'h0000_C000);
        rctrl(1, "R5 write 1 clears error");

        // R6: flush leaves error alone
        recv(1, "R4 empty read again");
        for (int i = 0; i < 3; i++) send(1, 32'hC000_0000 + i);
        rctrl(0, "R6 peer sees pending words");
        wctrl(1, 32'h0000_8008);
        rctrl(1, "R6 flush empties send, keeps error");
        rctrl(0, "R6 peer receive emptied");
        recv(0, "R6 read after flush returns last");
        wctrl(1, 32'h0000_C000);
        wctrl(0, 32'h0000_C000);

        // R7: disabled pop
        send(1, 32'h1234_5678);
        wctrl(0, 32'h0000_0000);
        recv(0, "R7 disabled read returns last");
        rctrl(0, "R7 disabled read no pop no error");

        // R8: receive level
        wctrl(0, 32'h0000_8400);
        #1 chk(irq_rx[0] === 1'b1, "R8 rx irq with data", {31'b0, irq_rx[0]}, 1);
        recv(0, "R2 word after re-enable");
        chk(irq_rx[0] === 1'b0, "R8 rx irq clears when empty", {31'b0, irq_rx[0]}, 0);

        // R9: drain pulse
        wctrl(0, 32'h0000_8404);
        send(0, 32'h5555_AAAA);
        chk(irq_tx[0] === 1'b0, "R9 no pulse while filling", {31'b0, irq_tx[0]}, 0);
        recv(1, "R2 pulse word");
        chk(irq_tx[0] === 1'b1, "R9 pulse on drain", {31'b0, irq_tx[0]}, 1);
        idle();
        chk(irq_tx[0] === 1'b0, "R9 pulse one cycle", {31'b0, irq_tx[0]}, 0);

        // Random mix, both sides enabled with receive interrupt on
        wctrl(0, 32'h0000_C400);
        wctrl(1, 32'h0000_C400);
        for (int n = 0; n < 800; n++) begin
            int s, op;
            s  = int'($urandom % 2);
            op = int'($urandom % 20);
            if (op < 9) send(s, $urandom);
            else if (op < 17) recv(s, "R2 random receive");
            else if (op < 19) rctrl(s, "R3 random control");
            else if ($urandom % 3 == 0) wctrl(s, 32'h0000_8408);
            else wctrl(s, 32'h0000_C400);
            chk(irq_rx[0] === (qsize(1) != 0), "R8 random rx irq side0",
                {31'b0, irq_rx[0]}, {31'b0, qsize(1) != 0});
            chk(irq_rx[1] === (qsize(0) != 0), "R8 random rx irq side1",
                {31'b0, irq_rx[1]}, {31'b0, qsize(0) != 0});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule